// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small table of 2-bit states and selects one state with the low word-address bits of the program counter. There are no tags, so branches whose addresses share those bits also share a state. The block supplies only the direction. The branch target is worked out later, in decode.

A fetch stage presents a PC on the lookup port and gets a taken/not-taken guess back in the same cycle. When a branch resolves, the pipeline presents that branch's PC and its real outcome on the update port, and the selected state moves to its next value. A saturating counter records how many resolved branches the table had guessed wrongly, for use in profiling.

The state machine is not the textbook saturating counter. From weakly-not-taken, a taken outcome jumps straight to strongly-taken. From weakly-taken, a not-taken outcome falls straight to strongly-not-taken.

Top module: `brdir_predictor`

## Requirements
- R1: The lookup output is combinational from `lkp_pc`. It is 1 (taken) when the selected state is 2'b10 or 2'b11, and 0 when the state is 2'b00 or 2'b01.
- R2: On an accepted update with `upd_taken`=1, the selected state moves 00→01, 01→11, 10→11 and 11→11.
- R3: On an accepted update with `upd_taken`=0, the selected state moves 00→00, 01→00, 10→00 and 11→10.
- R4: The slot index is PC bits [2 +: log2(SLOTS)]. PC bits [1:0] and all bits above the index take no part, so PCs that differ only there share one state.
- R5: While `rst_n` is low, every state is 2'b00 and `miss_count` is 0.
- R6: When `upd_valid` is 0, no state and no count changes, whatever `upd_pc` and `upd_taken` hold.
- R7: If a lookup and an update select the same slot in one cycle, the lookup returns the state before the update. The new state is visible from the next cycle on.
- R8: `miss_count` rises by exactly 1 for each accepted update whose outcome differs from the direction the slot predicted before that update, and by nothing otherwise.
- R9: `miss_count` saturates at 2^CNT_W−1 and never wraps.
- R10: Both SLOTS=4 and SLOTS=8 work. With 4 slots, the index is PC bits [3:2]; with 8 slots, it is PC bits [4:2].
- R11: Reset is asserted asynchronously and released through two flops. Updates in the first two clock edges after `rst_n` rises are ignored, and the update at the third edge is the first one accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_pc | input | ADDR_W | PC being fetched |
| lkp_taken | output | 1 | Predicted direction for `lkp_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| miss_count | output | CNT_W | Saturating count of wrong predictions |

## Verification
The lookup and the update can select the same slot in one cycle. The bench provokes this on purpose by walking one branch address through every transition, with `lkp_pc` equal to `upd_pc`. Each lookup is judged before the clock edge against the model's old state, and then against the new state one cycle later. A second pair of collisions uses PCs that differ only in bits outside the index, so that aliasing slots collide too. These are judged on an 8-slot and a 4-slot instance side by side.

// File: rtl/brdir_pkg.sv
package brdir_pkg;

  localparam logic [1:0] ST_NT_STRONG = 2'b00;
  localparam logic [1:0] ST_NT_WEAK   = 2'b01;
  localparam logic [1:0] ST_TK_WEAK   = 2'b10;
  localparam logic [1:0] ST_TK_STRONG = 2'b11;

  // Next state of one slot for a resolved outcome.
  function automatic logic [1:0] brdir_next(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    case (cur)
      ST_NT_STRONG: nxt = taken ? ST_NT_WEAK   : ST_NT_STRONG;
      ST_NT_WEAK:   nxt = taken ? ST_TK_STRONG : ST_NT_STRONG;
      ST_TK_WEAK:   nxt = taken ? ST_TK_STRONG : ST_NT_STRONG;
      default:      nxt = taken ? ST_TK_STRONG : ST_TK_WEAK;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/brdir_rst_sync.sv
module brdir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/brdir_index.sv
module brdir_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx
);
  // Byte-offset bits and bits above the index play no part.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[ADDR_W-1:IDX_W+2], pc[1:0]};
  assign idx = pc[2 +: IDX_W];
endmodule

// File: rtl/brdir_table.sv
module brdir_table
  import brdir_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [1:0]       wr_old
);
  logic [2*SLOTS-1:0] ent_all;

  for (genvar g = 0; g < SLOTS; g++) begin : gen_slot
    logic [1:0] st_q;
    logic [1:0] st_d;
    logic       hit;

    always_comb begin
      hit  = wr_en && (wr_idx == IDX_W'(g));
      st_d = brdir_next(st_q, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= ST_NT_STRONG;
      else if (hit) st_q <= st_d;
    end

    assign ent_all[2*g +: 2] = st_q;
  end

  assign rd_state = ent_all[{rd_idx, 1'b0} +: 2];
  assign wr_old   = ent_all[{wr_idx, 1'b0} +: 2];
endmodule

// File: rtl/brdir_misscnt.sv
module brdir_misscnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = inc && (count_q != '1);
    count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/brdir_predictor.sv
module brdir_predictor #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lkp_pc,
  output logic              lkp_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(SLOTS);

  logic             rst_n_q;
  logic [IDX_W-1:0] lkp_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [1:0]       lkp_state;
  logic [1:0]       upd_old;
  logic             upd_miss;

  brdir_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  brdir_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_idx (
    .pc  (lkp_pc),
    .idx (lkp_idx)
  );

  brdir_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_idx (
    .pc  (upd_pc),
    .idx (upd_idx)
  );

  brdir_table #(.SLOTS(SLOTS)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .rd_idx   (lkp_idx),
    .rd_state (lkp_state),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .wr_old   (upd_old)
  );

  assign lkp_taken = lkp_state[1];
  assign upd_miss  = upd_valid && (upd_old[1] != upd_taken);

  brdir_misscnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_q),
    .inc   (upd_miss),
    .count (miss_count)
  );
endmodule

// File: rtl/brdir_predictor_chk.sv
module brdir_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lkp_pc,
  input logic              lkp_taken,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [CNT_W-1:0]  miss_count
);
  // R5
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (miss_count == '0 && !lkp_taken));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(miss_count));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count == '1 |=> miss_count == '1);

  // R2
  taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && lkp_taken && lkp_pc == upd_pc)
      |=> (lkp_pc != $past(lkp_pc) || lkp_taken));

  // R3
  nt_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !lkp_taken && lkp_pc == upd_pc)
      |=> (lkp_pc != $past(lkp_pc) || !lkp_taken));
endmodule

bind brdir_predictor brdir_predictor_chk #(
  .ADDR_W (ADDR_W),
  .SLOTS  (SLOTS),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/brdir_predictor_tb_top.sv
module brdir_predictor_tb_top;
  localparam int AW   = 32;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] lkp_pc;
  logic [AW-1:0] upd_pc;
  logic          upd_valid;
  logic          upd_taken;
  logic          tk8, tk4;
  logic [CW-1:0] mc8, mc4;

  always #10 clk = ~clk;

  brdir_predictor #(.ADDR_W(AW), .SLOTS(8), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(tk8),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .miss_count(mc8)
  );

  brdir_predictor #(.ADDR_W(AW), .SLOTS(4), .CNT_W(CW)) dut4_i (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(tk4),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .miss_count(mc4)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int st8[8];
  int st4[4];
  int miss8 = 0;
  int miss4 = 0;
  int hold = 1000;

  // Transition table from R2 / R3
  function automatic int nxt(int s, bit t);
    case (s)
      0:       return t ? 1 : 0;
      1:       return t ? 3 : 0;
      2:       return t ? 3 : 0;
      default: return t ? 3 : 2;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One clock: drive, compare against model state, then advance model.
  task automatic step(string req, logic [AW-1:0] lpc, bit uv, logic [AW-1:0] upc, bit ut);
    int i8, i4, l8, l4;
    @(negedge clk);
    lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    l8 = int'((lpc >> 2) % 8);
    l4 = int'((lpc >> 2) % 4);
    chk(req, "lookup8", {31'd0, tk8}, (st8[l8] >= 2) ? 1 : 0);
    chk(req, "lookup4", {31'd0, tk4}, (st4[l4] >= 2) ? 1 : 0);
    chk(req, "miss8", {26'd0, mc8}, miss8);
    chk(req, "miss4", {26'd0, mc4}, miss4);
    if (hold > 0) hold--;
    else if (uv) begin
      i8 = int'((upc >> 2) % 8);
      i4 = int'((upc >> 2) % 4);
      if ((st8[i8] >= 2) != ut && miss8 < CMAX) miss8++;
      if ((st4[i4] >= 2) != ut && miss4 < CMAX) miss4++;
      st8[i8] = nxt(st8[i8], ut);
      st4[i4] = nxt(st4[i4], ut);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (st8[i]) st8[i] = 0;
    foreach (st4[i]) st4[i] = 0;
    rst_n = 1'b0; lkp_pc = '0; upd_pc = '0; upd_valid = 1'b0; upd_taken = 1'b0;

    // R5: updates during reset change nothing
    step("R5", 32'h4, 1, 32'h4, 1);
    step("R5", 32'h4, 1, 32'h4, 1);
    step("R5", 32'hC, 1, 32'h4, 0);

    // R11: two edges after release are ignored, the third is accepted
    @(posedge clk); #5 rst_n = 1'b1; hold = 2;
    step("R11", 32'h4, 1, 32'h4, 1);
    step("R11", 32'h4, 1, 32'h4, 1);
    step("R11", 32'h4, 1, 32'h4, 1);
    step("R11", 32'h4, 0, 32'h4, 0);
    chk("R11", "lookup8 after first accepted", {31'd0, tk8}, 0);
    chk("R11", "miss8 after first accepted", {26'd0, mc8}, 1);

    // R2 R7: taken walk on slot 2, lookup collides with update
    step("R2 R7", 32'h8, 1, 32'h8, 1);
    step("R2 R7", 32'h8, 1, 32'h8, 1);
    step("R2 R7", 32'h8, 1, 32'h8, 1);
    step("R1 R7", 32'h8, 0, 32'h8, 0);
    chk("R1", "strong taken lookup8", {31'd0, tk8}, 1);

    // R3 R7: not-taken walk back down
    step("R3 R7", 32'h8, 1, 32'h8, 0);
    step("R3 R7", 32'h8, 1, 32'h8, 0);
    step("R3 R7", 32'h8, 1, 32'h8, 0);
    step("R3", 32'h8, 0, 32'h8, 0);
    chk("R3", "back to 00 lookup8", {31'd0, tk8}, 0);

    // R3: 01 with not-taken drops to 00; R2: 10 with taken rises to 11
    step("R3", 32'h8, 1, 32'h8, 1);
    step("R3", 32'h8, 1, 32'h8, 0);
    step("R2", 32'h8, 1, 32'h8, 1);
    step("R2", 32'h8, 1, 32'h8, 1);
    step("R2", 32'h8, 1, 32'h8, 1);
    step("R2", 32'h8, 1, 32'h8, 0);
    step("R2", 32'h8, 1, 32'h8, 1);
    step("R2", 32'h8, 0, 32'h8, 0);

    // R6: idle update port leaves state and count alone
    step("R6", 32'h8, 0, 32'h8, 0);
    step("R6", 32'h8, 0, 32'h8, 0);
    step("R6", 32'h8, 0, 32'h8, 0);
    chk("R6", "lookup8 unchanged", {31'd0, tk8}, 1);

    // R4 R10: aliasing across high and byte-offset bits, 4 vs 8 slots
    step("R4", 32'h4, 1, 32'h24, 1);
    step("R4", 32'h7, 1, 32'hF000_0026, 1);
    step("R4", 32'h104, 0, 32'h0, 0);
    step("R4", 32'h5, 0, 32'h0, 0);
    step("R10", 32'h14, 1, 32'h34, 1);
    step("R10", 32'h14, 1, 32'h34, 1);
    step("R10", 32'h14, 0, 32'h0, 0);
    step("R10", 32'h34, 0, 32'h0, 0);
    chk("R10", "slot5 differs lookup8", {31'd0, tk8}, 1);
    chk("R10", "slot1 lookup4", {31'd0, tk4}, 1);
    step("R10", 32'h2C, 0, 32'h0, 0);
    chk("R10", "slot3 lookup8 untouched", {31'd0, tk8}, 0);

    // R8 R9: long mixed stream drives the counters to saturation
    for (int n = 0; n < 800; n++) begin
      logic [AW-1:0] p;
      p = AW'($urandom);
      step("R8 R9", AW'($urandom), 1, p, 1'($urandom));
    end
    step("R9", 32'h0, 0, 32'h0, 0);
    chk("R9", "miss8 saturated", {26'd0, mc8}, CMAX);
    chk("R9", "miss4 saturated", {26'd0, mc4}, CMAX);

    finish_run();
  end
endmodule